// File: doc/BRIEF.md
# LED Output Fault Detection Sequencer

This block runs the diagnostic cycle of a sixteen-channel constant-current LED driver. The serial command decoder hands it one-cycle pulses that open a detection window in one of three modes (open-circuit, short-circuit or both) and a pulse that closes the window. While the window is open, the block watches digital fault flags from the analog comparators for every channel. A channel counts only if its output switch is on and its brightness is not zero, and only in the cycles when the PWM stage actually drives it.

A per-channel counter measures how long each channel was driven inside the window. A fault is reported only for a channel that reached the minimum on-time and raised the flag of the selected mode at least once while it was driven. When the window closes, the sixteen pass/fail bits are loaded into a shift path. One bit leaves on the serial data output per serial clock pulse: channel 15 first, and 0 means a fault. The two-bit short-threshold code from the configuration passes straight through to the comparators.

Top module: `led_fault_seq`

## Requirements
- R1: While `cfg_rsv_mode` is 1, start pulses are ignored: `det_active` stays 0, and a following end pulse yields sixteen 1 bits.
- R2: In open mode (`cmd_start_open`), only `flag_open` can mark a channel faulty. `flag_short` has no effect.
- R3: In short mode (`cmd_start_short`), only `flag_short` can mark a channel faulty. `flag_open` has no effect.
- R4: In combined mode (`cmd_start_comb`), either flag marks the channel faulty.
- R5: A channel whose `ch_switch` bit is 0 or whose `ch_brt_nz` bit is 0 reports 1 whatever its flags are.
- R6: A channel driven for fewer than `ON_MIN_CYC` clock cycles inside the window reports 1, even when flagged.
- R7: A qualifying flag seen for a single driven cycle inside the window latches the fault until the next start.
- R8: After an end pulse, the k-th `shift_en` pulse (k = 1..16) puts the result of channel 16-k on `sdo` in the following cycle. Further pulses give 1, and `sdo` changes only after a `shift_en` pulse.
- R9: An accepted start clears all on-time counts and latched faults.
- R10: An end pulse with no window open loads sixteen 1 bits.
- R11: `thr_sel` equals `cfg_short_thr` in the same cycle. The codes 00, 01, 10 and 11 pick short thresholds of 1.8 V, 2.5 V, 3.0 V and 3.5 V.
- R12: `det_active` rises the cycle after an accepted start and falls the cycle after an end pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rsv_mode | input | 1 | Config detection-mode bit; 1 = reserved, detection blocked |
| cfg_short_thr | input | 2 | Config short-threshold code |
| cmd_start_open | input | 1 | Decoded pulse: start open detection |
| cmd_start_short | input | 1 | Decoded pulse: start short detection |
| cmd_start_comb | input | 1 | Decoded pulse: start combined detection |
| cmd_end | input | 1 | Decoded pulse: end detection, load results |
| ch_switch | input | NCH | Per-channel output switch bits |
| ch_brt_nz | input | NCH | Per-channel brightness-nonzero flags |
| ch_drive | input | NCH | Per-channel output currently driven |
| flag_open | input | NCH | Comparator: current at or below half of programmed |
| flag_short | input | NCH | Comparator: output voltage above threshold |
| shift_en | input | 1 | One pulse per serial clock rising edge |
| sdo | output | 1 | Serial result output |
| det_active | output | 1 | Detection window open |
| thr_sel | output | 2 | Threshold code to the short comparators |

## Verification
`det_active` is due one cycle after a start or end pulse, and `thr_sel` in the same cycle as its input. Each result bit is due on `sdo` one cycle after its `shift_en` pulse. The bench drives inputs on falling edges and samples on the next falling edge, so each value is read half a period after the register that produces it has updated. The driver computes every expected result word from the masks it applied and queues it. The monitor pulses `shift_en` seventeen times and compares the collected word with the queued entry, then checks that the seventeenth bit is a 1.

// File: rtl/fault_seq_pkg.sv
package fault_seq_pkg;
  typedef enum logic [1:0] {
    DM_OPEN  = 2'd0,
    DM_SHORT = 2'd1,
    DM_COMB  = 2'd2
  } det_mode_e;

  // Does the selected mode treat this flag pair as a fault?
  function automatic logic mode_hit(det_mode_e m, logic f_open, logic f_short);
    case (m)
      DM_OPEN:  return f_open;
      DM_SHORT: return f_short;
      DM_COMB:  return f_open | f_short;
      default:  return 1'b0;
    endcase
  endfunction

  // Result bit: 0 only for a tested, qualified, faulted channel
  function automatic logic pass_bit(logic tested, logic qualified, logic fault);
    return ~(tested & qualified & fault);
  endfunction
endpackage

// File: rtl/fs_ctrl.sv
module fs_ctrl
  import fault_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rsv_mode,
  input  logic      st_open,
  input  logic      st_short,
  input  logic      st_comb,
  input  logic      end_cmd,
  output logic      active,
  output det_mode_e mode,
  output logic      start_acc,
  output logic      end_in_win
);
  logic start_any;
  assign start_any  = st_open | st_short | st_comb;
  assign start_acc  = start_any & ~rsv_mode;
  assign end_in_win = end_cmd & active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      mode   <= DM_OPEN;
    end else if (start_acc) begin
      active <= 1'b1;
      if (st_comb)       mode <= DM_COMB;
      else if (st_short) mode <= DM_SHORT;
      else               mode <= DM_OPEN;
    end else if (end_cmd) begin
      active <= 1'b0;
    end
  end
endmodule

// File: rtl/fs_chan_mon.sv
module fs_chan_mon
  import fault_seq_pkg::*;
#(
  parameter int ON_MIN_CYC = 125,
  localparam int CNT_W = $clog2(ON_MIN_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic active,
  input  logic tested,
  input  logic drive,
  input  logic hit,
  output logic fault_q,
  output logic pass
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ON_MIN_CYC);

  logic [CNT_W-1:0] on_cnt;
  logic             live;
  logic             qualified;

  assign live      = active & tested & drive;
  assign qualified = (on_cnt == LIMIT);
  assign pass      = pass_bit(tested, qualified, fault_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_cnt  <= '0;
      fault_q <= 1'b0;
    end else if (clr) begin
      on_cnt  <= '0;
      fault_q <= 1'b0;
    end else begin
      if (live && !qualified) on_cnt <= on_cnt + 1'b1;
      if (live && hit)        fault_q <= 1'b1;
    end
  end
endmodule

// File: rtl/fs_result_shift.sv
module fs_result_shift #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [NCH-1:0] load_val,
  input  logic           shift_en,
  output logic [NCH-1:0] sh_q,
  output logic           sdo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '1;
      sdo  <= 1'b1;
    end else if (load) begin
      sh_q <= load_val;
    end else if (shift_en) begin
      sdo  <= sh_q[NCH-1];
      sh_q <= {sh_q[NCH-2:0], 1'b1};
    end
  end
endmodule

// File: rtl/led_fault_seq.sv
module led_fault_seq
  import fault_seq_pkg::*;
#(
  parameter int NCH        = 16,
  parameter int ON_MIN_CYC = 125
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_rsv_mode,
  input  logic [1:0]     cfg_short_thr,
  input  logic           cmd_start_open,
  input  logic           cmd_start_short,
  input  logic           cmd_start_comb,
  input  logic           cmd_end,
  input  logic [NCH-1:0] ch_switch,
  input  logic [NCH-1:0] ch_brt_nz,
  input  logic [NCH-1:0] ch_drive,
  input  logic [NCH-1:0] flag_open,
  input  logic [NCH-1:0] flag_short,
  input  logic           shift_en,
  output logic           sdo,
  output logic           det_active,
  output logic [1:0]     thr_sel
);
  det_mode_e      mode;
  logic           start_acc;
  logic           end_in_win;
  logic [NCH-1:0] fault_vec;
  logic [NCH-1:0] pass_vec;
  logic [NCH-1:0] load_val;
  logic [NCH-1:0] shift_q;

  assign thr_sel = cfg_short_thr;

  fs_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rsv_mode  (cfg_rsv_mode),
    .st_open   (cmd_start_open),
    .st_short  (cmd_start_short),
    .st_comb   (cmd_start_comb),
    .end_cmd   (cmd_end),
    .active    (det_active),
    .mode      (mode),
    .start_acc (start_acc),
    .end_in_win(end_in_win)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    fs_chan_mon #(.ON_MIN_CYC(ON_MIN_CYC)) u_mon (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (start_acc),
      .active (det_active),
      .tested (ch_switch[g] & ch_brt_nz[g]),
      .drive  (ch_drive[g]),
      .hit    (mode_hit(mode, flag_open[g], flag_short[g])),
      .fault_q(fault_vec[g]),
      .pass   (pass_vec[g])
    );
  end

  assign load_val = end_in_win ? pass_vec : '1;

  fs_result_shift #(.NCH(NCH)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cmd_end),
    .load_val(load_val),
    .shift_en(shift_en),
    .sh_q    (shift_q),
    .sdo     (sdo)
  );
endmodule

// File: rtl/fault_seq_chk.sv
module fault_seq_chk #(
  parameter int NCH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_rsv_mode,
  input logic           cmd_start_open,
  input logic           cmd_start_short,
  input logic           cmd_start_comb,
  input logic           cmd_end,
  input logic           shift_en,
  input logic           sdo,
  input logic           det_active,
  input logic           start_acc,
  input logic [NCH-1:0] fault_vec,
  input logic [NCH-1:0] shift_q
);
  logic start_any;
  assign start_any = cmd_start_open | cmd_start_short | cmd_start_comb;

  AST_RSV_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_any && cfg_rsv_mode && !det_active) |=> !det_active); // R1

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !start_acc |=> ((fault_vec & $past(fault_vec)) == $past(fault_vec))); // R7

  AST_SDO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sdo)); // R8

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (fault_vec == '0)); // R9

  AST_IDLE_END_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_end && !det_active) |=> (shift_q == '1)); // R10

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_any && !cfg_rsv_mode) |=> det_active); // R12

  AST_END_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_end && !start_any) |=> !det_active); // R12
endmodule

bind led_fault_seq fault_seq_chk #(.NCH(NCH)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_rsv_mode   (cfg_rsv_mode),
  .cmd_start_open (cmd_start_open),
  .cmd_start_short(cmd_start_short),
  .cmd_start_comb (cmd_start_comb),
  .cmd_end        (cmd_end),
  .shift_en       (shift_en),
  .sdo            (sdo),
  .det_active     (det_active),
  .start_acc      (start_acc),
  .fault_vec      (fault_vec),
  .shift_q        (shift_q)
);

// File: tb/led_fault_seq_bench.sv
module led_fault_seq_bench;
  localparam int NCH = 16;
  localparam int ON  = 125;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_rsv_mode = 1'b0;
  logic [1:0] cfg_short_thr = 2'b00;
  logic cmd_start_open = 1'b0, cmd_start_short = 1'b0, cmd_start_comb = 1'b0, cmd_end = 1'b0;
  logic [NCH-1:0] ch_switch = '0, ch_brt_nz = '0, ch_drive = '0, flag_open = '0, flag_short = '0;
  logic shift_en = 1'b0;
  logic sdo, det_active;
  logic [1:0] thr_sel;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [NCH-1:0] exp_q[$];
  string          tag_q[$];

  always #4 clk = ~clk;

  led_fault_seq #(.NCH(NCH), .ON_MIN_CYC(ON)) u_led_fault_seq (
    .clk(clk), .rst_n(rst_n), .cfg_rsv_mode(cfg_rsv_mode), .cfg_short_thr(cfg_short_thr),
    .cmd_start_open(cmd_start_open), .cmd_start_short(cmd_start_short),
    .cmd_start_comb(cmd_start_comb), .cmd_end(cmd_end),
    .ch_switch(ch_switch), .ch_brt_nz(ch_brt_nz), .ch_drive(ch_drive),
    .flag_open(flag_open), .flag_short(flag_short), .shift_en(shift_en),
    .sdo(sdo), .det_active(det_active), .thr_sel(thr_sel)
  );

  task automatic check(bit ok, string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // Monitor: reads each result word out through sdo and compares it with the queue
  initial begin
    forever begin
      logic [NCH-1:0] got;
      wait (exp_q.size() != 0);
      for (int k = 0; k < NCH; k++) begin
        @(negedge clk) shift_en = 1'b1;
        @(negedge clk) shift_en = 1'b0;
        got[NCH-1-k] = sdo;   // R8: channel 15 first
      end
      check(got == exp_q[0], tag_q[0], 32'(got), 32'(exp_q[0]));
      @(negedge clk) shift_en = 1'b1;
      @(negedge clk) shift_en = 1'b0;
      check(sdo == 1'b1, "R8 tail fill", 32'(sdo), 32'd1);
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  // mode: 0 open, 1 short, 2 combined
  task automatic run_window(int mode, logic [NCH-1:0] sw, logic [NCH-1:0] brt,
                            logic [NCH-1:0] on_long, logic [NCH-1:0] on_short,
                            logic [NCH-1:0] ofl, logic [NCH-1:0] sfl, logic [NCH-1:0] opulse,
                            bit do_end, string tag);
    logic [NCH-1:0] hit, qual, exp;
    ch_switch = sw;
    ch_brt_nz = brt;
    @(negedge clk);
    cmd_start_open  = (mode == 0);
    cmd_start_short = (mode == 1);
    cmd_start_comb  = (mode == 2);
    @(negedge clk);
    cmd_start_open = 1'b0; cmd_start_short = 1'b0; cmd_start_comb = 1'b0;
    check(det_active == 1'b1, "R12 rise after start", 32'(det_active), 32'd1);
    for (int c = 0; c < ON + 5; c++) begin
      ch_drive   = on_long | ((c < ON - 10) ? on_short : '0);
      flag_open  = ofl | ((c == 20) ? opulse : '0);
      flag_short = sfl;
      @(negedge clk);
    end
    ch_drive = '0; flag_open = '0; flag_short = '0;
    if (do_end) begin
      cmd_end = 1'b1;
      @(negedge clk) cmd_end = 1'b0;
      check(det_active == 1'b0, "R12 fall after end", 32'(det_active), 32'd0);
      case (mode)
        0:       hit = ofl | opulse;
        1:       hit = sfl;
        default: hit = ofl | opulse | sfl;
      endcase
      qual = sw & brt & on_long;
      exp  = ~(qual & hit);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      wait (exp_q.size() == 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sdo == 1'b1, "reset sdo", 32'(sdo), 32'd1);
    check(det_active == 1'b0, "reset det_active", 32'(det_active), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: threshold code passes through
    for (int t = 0; t < 4; t++) begin
      cfg_short_thr = 2'(t);
      #1;
      check(thr_sel == 2'(t), "R11 thr_sel", 32'(thr_sel), 32'(t));
    end

    run_window(0, '1, '1, '1, '0, 16'h8001, 16'h0F00, '0, 1, "R2 open mode");
    run_window(1, '1, '1, '1, '0, 16'h00F0, 16'hA005, '0, 1, "R3 short mode");
    run_window(2, '1, '1, '1, '0, 16'h0300, 16'h0018, 16'h4000, 1, "R4 R7 combined + one-cycle pulse");
    run_window(0, 16'hFF00, 16'hF0F0, '1, '0, '1, '0, '0, 1, "R5 untested channels");
    run_window(0, '1, '1, 16'h00FF, 16'hFF00, '1, '0, '0, 1, "R6 short on-time");
    run_window(0, '1, '1, '1, '0, '1, '0, '0, 0, "");
    run_window(0, '1, '1, '1, '0, 16'h0001, '0, '0, 1, "R9 restart clears");

    // R10: end with no open window
    @(negedge clk) cmd_end = 1'b1;
    @(negedge clk) cmd_end = 1'b0;
    exp_q.push_back('1); tag_q.push_back("R10 end without start");
    wait (exp_q.size() == 0);

    // R1: reserved mode blocks the start
    cfg_rsv_mode = 1'b1;
    @(negedge clk) cmd_start_short = 1'b1;
    @(negedge clk) cmd_start_short = 1'b0;
    check(det_active == 1'b0, "R1 reserved mode no window", 32'(det_active), 32'd0);
    ch_switch = '1; ch_brt_nz = '1; ch_drive = '1; flag_open = '1; flag_short = '1;
    repeat (ON + 5) @(negedge clk);
    ch_drive = '0; flag_open = '0; flag_short = '0;
    cmd_end = 1'b1;
    @(negedge clk) cmd_end = 1'b0;
    exp_q.push_back('1); tag_q.push_back("R1 reserved mode result");
    wait (exp_q.size() == 0);
    cfg_rsv_mode = 1'b0;

    repeat (4) @(negedge clk);
    report();
  end
endmodule